// File: doc/BRIEF.md
# Entry-Word Return Linkage Sequencer

This block carries out subroutine call and return linkage without any stack or link register. When a call is accepted for a routine whose entry word sits at address E, the sequencer writes the caller's return address into memory word E. It then reports E+1 as the next program counter, so the routine's body always begins one word past its entry. A return names the same entry address. The sequencer reads word E and jumps to whatever value it finds there.

The link lives in the routine's own entry word. Calling a routine again before it has returned therefore overwrites the earlier link, and the routine cannot be re-entered or called recursively. Every memory step waits on a ready handshake. The new program counter appears together with a one-cycle completion pulse. A requester keeps its request raised until the block accepts it. The block accepts a request only on a clock edge where `busy` was low. When a call and a return are both raised in the same cycle, the call is served first.

Top module: `entry_link_seq`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done` and `mem_req` are 0 and `next_pc` equals the `RESET_PC` parameter (default 0x0000).
- R2: A call that is accepted writes `call_link` into memory word `call_entry`. The write uses `mem_req`=1, `mem_we`=1, `mem_addr`=entry and `mem_wdata`=link, and it completes on the edge where `mem_ready` is 1.
- R3: One cycle after a call's write completes, `done` is 1 and `next_pc` equals the entry address plus one.
- R4: A return that is accepted reads memory word `ret_entry` with `mem_we`=0. One cycle after the read completes, `done` is 1 and `next_pc` equals the `mem_rdata` value that was present at completion.
- R5: While `mem_req` is 1 and `mem_ready` is 0, the memory request stays raised and `mem_addr`, `mem_we` and `mem_wdata` stay unchanged.
- R6: `busy` is 1 from the edge that accepts a request until the edge that completes its memory step. While `busy` is 1, no further request starts. A request held raised during that time is served afterwards and is not lost. When `busy` is 0, `mem_req` is 0.
- R7: When `call_valid` and `ret_valid` are both 1 on an accepting edge, the call is taken. The return is taken later, and it sees the link that the call wrote.
- R8: `done` is 1 for exactly one clock per completed request. `next_pc` changes only in a cycle where `done` is 1.
- R9: The entry-plus-one arithmetic wraps modulo 2^16, so a call to 0xFFFF yields `next_pc` = 0x0000.
- R10: A second call to the same entry before a return replaces the stored link. Every later return through that entry yields the most recently written link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_valid | input | 1 | Call request, held until accepted |
| call_entry | input | 16 | Entry-word address of the called routine |
| call_link | input | 16 | Return address to store (call address plus one) |
| ret_valid | input | 1 | Return request, held until accepted |
| ret_entry | input | 16 | Entry-word address to return through |
| busy | output | 1 | A request is in progress; new requests wait |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Memory completes the access on this edge |
| next_pc | output | 16 | Program counter after the last completed request |
| done | output | 1 | One-cycle pulse when next_pc has been updated |

## Verification
A call and a return can arrive in the same cycle, and both want the single memory port. The bench raises both requests on one falling edge. They name the same entry, so the call's write and the return's read touch the same word. It then checks that the write reaches memory first and that the return's `next_pc` is exactly the link that call stored. If the priority were swapped, the result would be the word's previous contents, and if a request were dropped, a scoreboard entry would be left unconsumed.

// File: rtl/entry_link_pkg.sv
package entry_link_pkg;

    localparam int unsigned LINK_AW = 16;
    localparam int unsigned LINK_DW = LINK_AW;

    typedef logic [LINK_AW-1:0] link_addr_t;
    typedef logic [LINK_DW-1:0] link_word_t;

    typedef enum logic {
        OP_CALL = 1'b0,
        OP_RET  = 1'b1
    } link_op_e;

    typedef enum logic [1:0] {
        LS_IDLE  = 2'd0,
        LS_WRITE = 2'd1,
        LS_READ  = 2'd2
    } lseq_state_e;

    typedef struct packed {
        link_op_e   op;
        link_addr_t entry;
        link_word_t link;
    } link_req_t;

    typedef struct packed {
        logic       req;
        logic       we;
        link_addr_t addr;
        link_word_t wdata;
    } mem_cmd_t;

    function automatic link_addr_t body_start(input link_addr_t entry);
        return entry + link_addr_t'(1);
    endfunction

endpackage

// File: rtl/entry_link_arb.sv
module entry_link_arb
    import entry_link_pkg::*;
(
    input  logic       idle,
    input  logic       call_valid,
    input  link_addr_t call_entry,
    input  link_word_t call_link,
    input  logic       ret_valid,
    input  link_addr_t ret_entry,
    output logic       grant,
    output link_req_t  granted
);
    always_comb begin
        grant   = idle & (call_valid | ret_valid);
        granted = '0;
        if (call_valid) begin
            granted.op    = OP_CALL;
            granted.entry = call_entry;
            granted.link  = call_link;
        end else begin
            granted.op    = OP_RET;
            granted.entry = ret_entry;
            granted.link  = '0;
        end
    end
endmodule

// File: rtl/entry_link_ctrl.sv
module entry_link_ctrl
    import entry_link_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        grant,
    input  link_req_t   granted,
    input  logic        mem_ready,
    output lseq_state_e state,
    output link_req_t   active,
    output logic        call_fin,
    output logic        ret_fin
);
    lseq_state_e state_q, state_d;
    link_req_t    active_q, active_d;

    always_comb begin
        state_d  = state_q;
        active_d = active_q;
        unique case (state_q)
            LS_IDLE: begin
                if (grant) begin
                    active_d = granted;
                    state_d  = (granted.op == OP_CALL) ? LS_WRITE : LS_READ;
                end
            end
            LS_WRITE: if (mem_ready) state_d = LS_IDLE;
            LS_READ:  if (mem_ready) state_d = LS_IDLE;
            default:  state_d = LS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= LS_IDLE;
            active_q <= '0;
        end else begin
            state_q  <= state_d;
            active_q <= active_d;
        end
    end

    assign state    = state_q;
    assign active   = active_q;
    assign call_fin = (state_q == LS_WRITE) && mem_ready;
    assign ret_fin  = (state_q == LS_READ) && mem_ready;

    AST_FIN_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(call_fin && ret_fin)); // R8
    AST_GRANT_HOLDS_REQ: assert property (@(posedge clk) disable iff (rst)
        (grant && state_q == LS_IDLE) |=> (active_q.entry == $past(granted.entry))); // R6
endmodule

// File: rtl/entry_link_memif.sv
module entry_link_memif
    import entry_link_pkg::*;
(
    input  lseq_state_e state,
    input  link_req_t   active,
    output mem_cmd_t    cmd
);
    always_comb begin
        cmd = '0;
        unique case (state)
            LS_WRITE: begin
                cmd.req   = 1'b1;
                cmd.we    = 1'b1;
                cmd.addr  = active.entry;
                cmd.wdata = active.link;
            end
            LS_READ: begin
                cmd.req   = 1'b1;
                cmd.we    = 1'b0;
                cmd.addr  = active.entry;
            end
            default: cmd = '0;
        endcase
    end
endmodule

// File: rtl/entry_link_pc.sv
module entry_link_pc
    import entry_link_pkg::*;
#(
    parameter link_addr_t RESET_PC = '0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       call_fin,
    input  logic       ret_fin,
    input  link_addr_t entry,
    input  link_word_t rdata,
    output link_addr_t pc,
    output logic       done
);
    link_addr_t pc_q;
    logic       done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= RESET_PC;
            done_q <= 1'b0;
        end else begin
            done_q <= call_fin | ret_fin;
            if (call_fin) begin
                pc_q <= body_start(entry);
            end else if (ret_fin) begin
                pc_q <= rdata;
            end
        end
    end

    assign pc   = pc_q;
    assign done = done_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R8
    AST_PC_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        !done_q |-> (pc_q == $past(pc_q))); // R8
endmodule

// File: rtl/entry_link_seq.sv
module entry_link_seq
    import entry_link_pkg::*;
#(
    parameter logic [15:0] RESET_PC = 16'h0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        call_valid,
    input  logic [15:0] call_entry,
    input  logic [15:0] call_link,
    input  logic        ret_valid,
    input  logic [15:0] ret_entry,
    output logic        busy,
    output logic        mem_req,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_wdata,
    input  logic [15:0] mem_rdata,
    input  logic        mem_ready,
    output logic [15:0] next_pc,
    output logic        done
);
    lseq_state_e state;
    link_req_t   active;
    link_req_t   granted;
    mem_cmd_t    cmd;
    logic        grant;
    logic        call_fin;
    logic        ret_fin;

    entry_link_arb u_arb (
        .idle       (state == LS_IDLE),
        .call_valid (call_valid),
        .call_entry (call_entry),
        .call_link  (call_link),
        .ret_valid  (ret_valid),
        .ret_entry  (ret_entry),
        .grant      (grant),
        .granted    (granted)
    );

    entry_link_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .grant     (grant),
        .granted   (granted),
        .mem_ready (mem_ready),
        .state     (state),
        .active    (active),
        .call_fin  (call_fin),
        .ret_fin   (ret_fin)
    );

    entry_link_memif u_memif (
        .state  (state),
        .active (active),
        .cmd    (cmd)
    );

    entry_link_pc #(.RESET_PC(RESET_PC)) u_pc (
        .clk      (clk),
        .rst      (rst),
        .call_fin (call_fin),
        .ret_fin  (ret_fin),
        .entry    (active.entry),
        .rdata    (mem_rdata),
        .pc       (next_pc),
        .done     (done)
    );

    assign busy      = (state != LS_IDLE);
    assign mem_req   = cmd.req;
    assign mem_we    = cmd.we;
    assign mem_addr  = cmd.addr;
    assign mem_wdata = cmd.wdata;

    AST_STALL_STABLE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R5
    AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req); // R6
    AST_CALL_WINS: assert property (@(posedge clk) disable iff (rst)
        (!busy && call_valid && ret_valid) |=> (mem_req && mem_we && mem_addr == $past(call_entry))); // R7
    AST_CALL_PC: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_ready) |=> (done && next_pc == 16'($past(mem_addr) + 16'd1))); // R3
    AST_RET_PC: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_ready) |=> (done && next_pc == $past(mem_rdata))); // R4
    AST_WRITE_DATA: assert property (@(posedge clk) disable iff (rst)
        (!busy && call_valid) |=> (mem_wdata == $past(call_link))); // R2
endmodule

// File: tb/entry_link_seq_test.sv
`timescale 1ns/1ps
module entry_link_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        call_valid = 1'b0;
    logic [15:0] call_entry = '0;
    logic [15:0] call_link = '0;
    logic        ret_valid = 1'b0;
    logic [15:0] ret_entry = '0;
    logic        busy, mem_req, mem_we, done;
    logic [15:0] mem_addr, mem_wdata, next_pc;
    logic [15:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;

    always #2 clk = ~clk;

    entry_link_seq uut (
        .clk(clk), .rst(rst),
        .call_valid(call_valid), .call_entry(call_entry), .call_link(call_link),
        .ret_valid(ret_valid), .ret_entry(ret_entry),
        .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .next_pc(next_pc), .done(done)
    );

    int errors = 0;
    int checks = 0;
    int stall = 0;
    int cycles = 0;
    logic [15:0] model_mem [int];
    logic [15:0] shadow [int];
    logic [15:0] exp_pc [$];
    string       exp_tag [$];
    logic [31:0] exp_wr [$];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model with programmable stall
    initial begin : mem_model
        int waited = 0;
        forever begin
            @(negedge clk);
            if (!rst && mem_req) begin
                if (waited >= stall) begin
                    mem_ready = 1'b1;
                    mem_rdata = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 16'h0000;
                    if (mem_we) begin
                        if (exp_wr.size() == 0) begin
                            check(1'b0, "R2 unexpected write", {mem_addr, mem_wdata}, 32'h0);
                        end else begin
                            logic [31:0] w;
                            w = exp_wr.pop_front();
                            check({mem_addr, mem_wdata} == w, "R2 write addr/data", {mem_addr, mem_wdata}, w);
                        end
                        model_mem[int'(mem_addr)] = mem_wdata;
                    end
                    waited = 0;
                end else begin
                    mem_ready = 1'b0;
                    waited++;
                end
            end else begin
                mem_ready = 1'b0;
                waited = 0;
            end
        end
    end

    // scoreboard monitor
    initial begin : monitor
        bit prev_done = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (done && prev_done)
                    check(1'b0, "R8 done longer than one cycle", 32'd1, 32'd0);
                if (done) begin
                    if (exp_pc.size() == 0) begin
                        check(1'b0, "R8 unexpected done", {16'h0, next_pc}, 32'h0);
                    end else begin
                        logic [15:0] e;
                        string t;
                        e = exp_pc.pop_front();
                        t = exp_tag.pop_front();
                        check(next_pc == e, t, {16'h0, next_pc}, {16'h0, e});
                    end
                end
                prev_done = done;
            end
        end
    end

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                checks++;
                $display("FAIL watchdog R6 actual=hung expected=finished");
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    task automatic do_call(input logic [15:0] e, input logic [15:0] lk, input string tag);
        @(negedge clk);
        call_valid = 1'b1; call_entry = e; call_link = lk;
        while (busy) @(negedge clk);
        exp_wr.push_back({e, lk});
        exp_pc.push_back(e + 16'd1);
        exp_tag.push_back(tag);
        shadow[int'(e)] = lk;
        @(negedge clk);
        call_valid = 1'b0;
    endtask

    task automatic do_ret(input logic [15:0] e, input string tag);
        @(negedge clk);
        ret_valid = 1'b1; ret_entry = e;
        while (busy) @(negedge clk);
        exp_pc.push_back(shadow.exists(int'(e)) ? shadow[int'(e)] : 16'h0000);
        exp_tag.push_back(tag);
        @(negedge clk);
        ret_valid = 1'b0;
    endtask

    task automatic do_both(input logic [15:0] ce, input logic [15:0] cl, input logic [15:0] re);
        @(negedge clk);
        call_valid = 1'b1; call_entry = ce; call_link = cl;
        ret_valid  = 1'b1; ret_entry  = re;
        while (busy) @(negedge clk);
        exp_wr.push_back({ce, cl});
        exp_pc.push_back(ce + 16'd1);
        exp_tag.push_back("R7 call served first");
        shadow[int'(ce)] = cl;
        @(negedge clk);
        call_valid = 1'b0;
        check(busy == 1'b1, "R6 busy after accept", {31'h0, busy}, 32'd1);
        while (busy) @(negedge clk);
        exp_pc.push_back(shadow[int'(re)]);
        exp_tag.push_back("R7 return sees call link");
        @(negedge clk);
        ret_valid = 1'b0;
    endtask

    task automatic drain;
        int n = 0;
        while ((exp_pc.size() != 0 || busy) && n < 200) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
    endtask

    initial begin : main
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && mem_req == 1'b0, "R1 outputs in reset",
              {29'h0, busy, done, mem_req}, 32'h0);
        check(next_pc == 16'h0000, "R1 next_pc in reset", {16'h0, next_pc}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && mem_req == 1'b0 && next_pc == 16'h0000,
              "R1 after release", {13'h0, busy, done, mem_req, next_pc}, 32'h0);

        // basic call and return, no stall
        do_call(16'h1000, 16'h0201, "R3 call pc");
        drain();
        do_ret(16'h1000, "R4 return pc");
        drain();

        // stalled call with a held second request
        stall = 3;
        do_call(16'h1200, 16'h0333, "R5 stalled call pc");
        check(busy == 1'b1 && mem_req == 1'b1 && mem_we == 1'b1, "R6 busy while stalled",
              {29'h0, busy, mem_req, mem_we}, 32'h7);
        do_call(16'h1300, 16'h0444, "R6 held call pc");
        drain();
        do_ret(16'h1200, "R5 stalled return pc");
        drain();
        stall = 0;

        // wrap
        do_call(16'hFFFF, 16'h7777, "R9 wrap pc");
        drain();
        check(next_pc == 16'h0000, "R9 next_pc wraps", {16'h0, next_pc}, 32'h0);

        // simultaneous call and return to the same entry
        model_mem[int'(16'h2000)] = 16'hDEAD;
        shadow[int'(16'h2000)]    = 16'hDEAD;
        do_both(16'h2000, 16'h0055, 16'h2000);
        drain();

        // non-reentrant overwrite
        do_call(16'h3000, 16'h0100, "R10 first call pc");
        do_call(16'h3000, 16'h3050, "R10 nested call pc");
        do_ret(16'h3000, "R10 first return gets latest link");
        do_ret(16'h3000, "R10 second return repeats latest link");
        drain();
        check(next_pc == 16'h3050, "R10 final pc", {16'h0, next_pc}, 32'h3050);

        // return through preloaded word with stall
        stall = 2;
        model_mem[int'(16'h4000)] = 16'hBEEF;
        shadow[int'(16'h4000)]    = 16'hBEEF;
        do_ret(16'h4000, "R4 preloaded return pc");
        drain();
        stall = 0;

        check(exp_pc.size() == 0, "R8 every request produced done", exp_pc.size(), 32'h0);
        check(exp_wr.size() == 0, "R2 every call wrote memory", exp_wr.size(), 32'h0);
        check(busy == 1'b0 && mem_req == 1'b0, "R6 idle at end", {30'h0, busy, mem_req}, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule